// File: doc/BRIEF.md
# Attribute-Driven Write Buffer

This block sits between the data-write port of a processor and a memory port. Each write request arrives with two region attributes, bufferable and cachable, a flag saying whether the write hit the data cache, and a flag marking it as part of a swap. From these four bits the block decides what happens to the write. It can be queued in a first-in first-out store of address/data pairs, written straight to memory while the processor waits, or absorbed by the cache alone with no memory traffic.

Queued entries retire to memory, oldest first, over a valid/ready port. A direct write uses that same port and carries a flag that tells it apart from a retiring entry. The block also arbitrates two waiting paths. A read in a bufferable, non-cachable region and any cache linefill are granted only once the queue is empty. This keeps memory from being read ahead of data that is still queued.

The processor side uses a valid/ready handshake. The processor holds its request until it sees ready, and a low ready is the stall.

Top module: `wbuf_top`

## Requirements
- R1: After a synchronous active-high reset, `buf_empty` is 1, `mem_valid` is 0 and `cache_upd` is 0.
- R2: Queued writes leave on the memory port in acceptance order, each with the accepted address and data and with `mem_direct` = 0. Each queued write leaves exactly once.
- R3: A write with bufferable=0 and cachable=0 is not queued. It waits until the queue is empty, then appears on the memory port with `mem_direct` = 1. `cpu_wr_ready` stays low until that memory handshake has completed.
- R4: A write with bufferable=0 and cachable=1 is queued whether it hits or misses. When it hits, `cache_upd` = 1 with `cache_dirty` = 0 in the cycle after acceptance.
- R5: A write with bufferable=1 and cachable=0 is queued. When its swap flag is 1, it is handled as a direct write as in R3.
- R6: A write with bufferable=1 and cachable=1 that hits is accepted at once. It gives `cache_upd` = 1 with `cache_dirty` = 1 in the next cycle and produces no memory traffic. If it misses, it is queued and gives no cache update.
- R7: The queue holds DEPTH (16) entries. A write that must be queued while 16 entries are held sees `cpu_wr_ready` = 0 until an entry retires.
- R8: `rd_grant` follows `rd_req` at once unless the read attributes are bufferable=1 and cachable=0. For such reads `rd_grant` is given only while the queue is empty.
- R9: `fill_grant` is given for `fill_req` only while the queue is empty and no direct write is in progress.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_direct` hold their values into the next cycle.
- R11: `buf_empty` is 1 exactly when no entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_valid | input | 1 | Write request present, held until accepted |
| cpu_wr_addr | input | AW | Write address |
| cpu_wr_data | input | DW | Write data |
| cpu_wr_bufable | input | 1 | Region bufferable attribute |
| cpu_wr_cachable | input | 1 | Region cachable attribute |
| cpu_wr_hit | input | 1 | Write hit the data cache |
| cpu_wr_swap | input | 1 | Write belongs to a swap operation |
| cpu_wr_ready | output | 1 | Write accepted this cycle; low means stall |
| cache_upd | output | 1 | Cache line update for the write accepted last cycle |
| cache_dirty | output | 1 | Mark the updated line dirty |
| rd_req | input | 1 | Read waiting for permission |
| rd_bufable | input | 1 | Read region bufferable attribute |
| rd_cachable | input | 1 | Read region cachable attribute |
| rd_grant | output | 1 | Read may proceed |
| fill_req | input | 1 | Cache linefill (miss or prefetch) waiting |
| fill_grant | output | 1 | Linefill may start |
| buf_empty | output | 1 | Queue holds no entries |
| mem_valid | output | 1 | Memory write presented |
| mem_ready | input | 1 | Memory accepts the presented write |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| mem_direct | output | 1 | Presented write is a direct, unqueued write |

## Verification
The bench fills the queue while memory is held off. It then checks that a seventeenth write stalls and that a design which overwrote the oldest entry or dropped the write shows up as a missing or corrupted transfer. A direct write is issued behind queued entries, so a design that let it overtake the queue, or released the processor before memory accepted it, fails either the order check or the ready check. Reads and linefills are requested while the queue is non-empty to catch grants given too early. A long random mix of all attribute and hit combinations, under random memory back-pressure, catches a wrong policy decode as extra, missing or wrongly flagged memory writes and as wrong cache updates.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    ACT_DIRECT = 2'd0,
    ACT_QUEUE  = 2'd1,
    ACT_CACHE  = 2'd2
  } wb_act_e;
endpackage

// File: rtl/wbuf_policy.sv
module wbuf_policy
  import wbuf_pkg::*;
(
  input  logic    bufable,
  input  logic    cachable,
  input  logic    hit,
  input  logic    swap,
  output wb_act_e act,
  output logic    upd,
  output logic    dirty
);
  always_comb begin
    unique case ({bufable, cachable})
      2'b00:   act = ACT_DIRECT;
      2'b10:   act = swap ? ACT_DIRECT : ACT_QUEUE;
      2'b01:   act = ACT_QUEUE;
      default: act = hit ? ACT_CACHE : ACT_QUEUE;
    endcase
    upd   = cachable & hit;
    dirty = bufable & cachable & hit;
  end
endmodule

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [AW+DW-1:0] store [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign {head_addr, head_data} = store[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == FULLV);
  assign count = cnt;
endmodule

// File: rtl/wbuf_direct.sv
module wbuf_direct #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] d_addr,
  output logic [DW-1:0] d_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      d_addr <= '0;
      d_data <= '0;
    end else begin
      done <= busy & mem_ready;
      if (start) begin
        busy   <= 1'b1;
        d_addr <= in_addr;
        d_data <= in_data;
      end else if (busy && mem_ready) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr_valid,
  input  logic [AW-1:0] cpu_wr_addr,
  input  logic [DW-1:0] cpu_wr_data,
  input  logic          cpu_wr_bufable,
  input  logic          cpu_wr_cachable,
  input  logic          cpu_wr_hit,
  input  logic          cpu_wr_swap,
  output logic          cpu_wr_ready,
  output logic          cache_upd,
  output logic          cache_dirty,
  input  logic          rd_req,
  input  logic          rd_bufable,
  input  logic          rd_cachable,
  output logic          rd_grant,
  input  logic          fill_req,
  output logic          fill_grant,
  output logic          buf_empty,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          mem_direct
);
  localparam int CW = $clog2(DEPTH + 1);

  wb_act_e       act;
  logic          pol_upd, pol_dirty;
  logic          q_full, q_empty, q_push, q_pop;
  logic [CW-1:0] q_count;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_data;
  logic          d_busy, d_done, d_start;
  logic [AW-1:0] d_addr;
  logic [DW-1:0] d_data;
  logic          accept;

  wbuf_policy u_pol (
    .bufable  (cpu_wr_bufable),
    .cachable (cpu_wr_cachable),
    .hit      (cpu_wr_hit),
    .swap     (cpu_wr_swap),
    .act      (act),
    .upd      (pol_upd),
    .dirty    (pol_dirty)
  );

  wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (q_push),
    .push_addr (cpu_wr_addr),
    .push_data (cpu_wr_data),
    .pop       (q_pop),
    .head_addr (q_addr),
    .head_data (q_data),
    .empty     (q_empty),
    .full      (q_full),
    .count     (q_count)
  );

  wbuf_direct #(.AW(AW), .DW(DW)) u_dir (
    .clk       (clk),
    .rst       (rst),
    .start     (d_start),
    .in_addr   (cpu_wr_addr),
    .in_data   (cpu_wr_data),
    .mem_ready (mem_ready),
    .busy      (d_busy),
    .done      (d_done),
    .d_addr    (d_addr),
    .d_data    (d_data)
  );

  // Direct writes start only behind an empty queue, keeping write order.
  assign d_start = cpu_wr_valid && (act == ACT_DIRECT) && q_empty && !d_busy && !d_done;

  always_comb begin
    unique case (act)
      ACT_CACHE: cpu_wr_ready = cpu_wr_valid;
      ACT_QUEUE: cpu_wr_ready = cpu_wr_valid && !q_full;
      default:   cpu_wr_ready = cpu_wr_valid && d_done;
    endcase
  end

  assign accept = cpu_wr_valid && cpu_wr_ready;
  assign q_push = accept && (act == ACT_QUEUE);
  assign q_pop  = !d_busy && !q_empty && mem_ready;

  assign mem_valid  = d_busy || !q_empty;
  assign mem_addr   = d_busy ? d_addr : q_addr;
  assign mem_data   = d_busy ? d_data : q_data;
  assign mem_direct = d_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_upd   <= 1'b0;
      cache_dirty <= 1'b0;
    end else begin
      cache_upd   <= accept && pol_upd;
      cache_dirty <= accept && pol_dirty;
    end
  end

  assign buf_empty  = q_empty;
  assign rd_grant   = rd_req && (!(rd_bufable && !rd_cachable) || q_empty);
  assign fill_grant = fill_req && q_empty && !d_busy;
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_wr_valid,
  input logic          cpu_wr_ready,
  input logic          cpu_wr_bufable,
  input logic          cpu_wr_cachable,
  input logic          cpu_wr_hit,
  input logic          cache_upd,
  input logic          cache_dirty,
  input logic          rd_grant,
  input logic          rd_bufable,
  input logic          rd_cachable,
  input logic          fill_grant,
  input logic          buf_empty,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [31:0]   mem_addr,
  input logic [31:0]   mem_data,
  input logic          mem_direct,
  input logic [CW-1:0] q_count
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (buf_empty && !mem_valid && !cache_upd));

  assert_direct_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_direct) |-> (q_count == '0));

  assert_wb_hit_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr_valid && cpu_wr_ready && cpu_wr_bufable && cpu_wr_cachable && cpu_wr_hit)
      |=> (cache_upd && cache_dirty));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    q_count <= FULLV);

  assert_rd_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_grant && rd_bufable && !rd_cachable) |-> buf_empty);

  assert_fill_wait_R9: assert property (@(posedge clk) disable iff (rst)
    fill_grant |-> (buf_empty && !(mem_valid && mem_direct)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_data) && $stable(mem_direct)));
endmodule

bind wbuf_top wbuf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cpu_wr_valid    (cpu_wr_valid),
  .cpu_wr_ready    (cpu_wr_ready),
  .cpu_wr_bufable  (cpu_wr_bufable),
  .cpu_wr_cachable (cpu_wr_cachable),
  .cpu_wr_hit      (cpu_wr_hit),
  .cache_upd       (cache_upd),
  .cache_dirty     (cache_dirty),
  .rd_grant        (rd_grant),
  .rd_bufable      (rd_bufable),
  .rd_cachable     (rd_cachable),
  .fill_grant      (fill_grant),
  .buf_empty       (buf_empty),
  .mem_valid       (mem_valid),
  .mem_ready       (mem_ready),
  .mem_addr        (mem_addr),
  .mem_data        (mem_data),
  .mem_direct      (mem_direct),
  .q_count         (q_count)
);

// File: tb/sim_wbuf_top.sv
`timescale 1ns/1ps
module sim_wbuf_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_valid = 1'b0;
  logic [31:0] cpu_wr_addr = '0;
  logic [31:0] cpu_wr_data = '0;
  logic        cpu_wr_bufable = 1'b0;
  logic        cpu_wr_cachable = 1'b0;
  logic        cpu_wr_hit = 1'b0;
  logic        cpu_wr_swap = 1'b0;
  logic        cpu_wr_ready;
  logic        cache_upd, cache_dirty;
  logic        rd_req = 1'b0, rd_bufable = 1'b0, rd_cachable = 1'b0;
  logic        rd_grant;
  logic        fill_req = 1'b0;
  logic        fill_grant;
  logic        buf_empty;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data;
  logic        mem_direct;

  int tests = 0;
  int fails = 0;
  bit hold_ready = 1'b0;
  logic [64:0] expq [$];

  always #2.5 clk = ~clk;

  wbuf_top u0 (
    .clk(clk), .rst(rst),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .cpu_wr_bufable(cpu_wr_bufable), .cpu_wr_cachable(cpu_wr_cachable),
    .cpu_wr_hit(cpu_wr_hit), .cpu_wr_swap(cpu_wr_swap), .cpu_wr_ready(cpu_wr_ready),
    .cache_upd(cache_upd), .cache_dirty(cache_dirty),
    .rd_req(rd_req), .rd_bufable(rd_bufable), .rd_cachable(rd_cachable), .rd_grant(rd_grant),
    .fill_req(fill_req), .fill_grant(fill_grant), .buf_empty(buf_empty),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_direct(mem_direct)
  );

  // 0 = direct, 1 = queued, 2 = cache only
  function automatic int exp_act(bit b, bit c, bit h, bit s);
    if (!b && !c) return 0;
    if (b && !c)  return s ? 0 : 1;
    if (!b && c)  return 1;
    return h ? 2 : 1;
  endfunction

  function automatic bit exp_upd(bit b, bit c, bit h);
    return c && h;
  endfunction

  task automatic check(bit ok, string req, string what, longint act_v, longint exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  // Memory sink: random back-pressure, scoreboard compare on each handshake.
  always @(negedge clk) begin
    mem_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
    #1;
    if (!rst && mem_valid && mem_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2", "unexpected memory write", {mem_direct, mem_addr}, 0);
      end else begin
        logic [64:0] e;
        e = expq.pop_front();
        check({mem_direct, mem_addr, mem_data} == e, e[64] ? "R3" : "R2",
              "memory write {direct,addr,data}",
              {mem_direct, mem_addr[31:0]}, {e[64], e[63:32]});
        check(mem_data == e[31:0], e[64] ? "R3" : "R2", "memory data", mem_data, e[31:0]);
      end
    end
  end

  task automatic do_write(logic [31:0] a, logic [31:0] d, bit b, bit c, bit h, bit s,
                          int stall_chk, string tag);
    int act;
    @(negedge clk);
    cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
    cpu_wr_bufable = b; cpu_wr_cachable = c; cpu_wr_hit = h; cpu_wr_swap = s;
    act = exp_act(b, c, h, s);
    if (act == 0) expq.push_back({1'b1, a, d});
    for (int i = 0; i < stall_chk; i++) begin
      #1;
      check(!cpu_wr_ready, tag, "processor not stalled", cpu_wr_ready, 0);
      @(negedge clk);
    end
    if (stall_chk > 0) hold_ready = 1'b0;
    #1;
    while (!cpu_wr_ready) begin
      @(negedge clk);
      #1;
    end
    if (act == 1) expq.push_back({1'b0, a, d});
    @(posedge clk);
    @(negedge clk);
    cpu_wr_valid = 1'b0;
    #1;
    check(cache_upd == exp_upd(b, c, h), (act == 2) ? "R6" : (c ? "R4" : "R5"),
          "cache_upd", cache_upd, exp_upd(b, c, h));
    if (exp_upd(b, c, h))
      check(cache_dirty == b, b ? "R6" : "R4", "cache_dirty", cache_dirty, b);
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(buf_empty && !mem_valid)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check(buf_empty == 1'b1, "R1", "buf_empty after reset", buf_empty, 1);
    check(mem_valid == 1'b0, "R1", "mem_valid after reset", mem_valid, 0);
    check(cache_upd == 1'b0, "R1", "cache_upd after reset", cache_upd, 0);

    // R7 fill all 16 entries with memory held off, then 17th stalls
    hold_ready = 1'b1;
    for (int i = 0; i < 16; i++)
      do_write(32'h1000 + i * 4, 32'hA000_0000 + i, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R4");
    @(negedge clk); #1;
    check(buf_empty == 1'b0, "R11", "buf_empty with entries", buf_empty, 0);
    // R8 / R9 with entries held
    rd_req = 1'b1; rd_bufable = 1'b1; rd_cachable = 1'b0; #0.1;
    check(rd_grant == 1'b0, "R8", "rd_grant B1C0 non-empty", rd_grant, 0);
    rd_bufable = 1'b0; rd_cachable = 1'b1; #0.1;
    check(rd_grant == 1'b1, "R8", "rd_grant B0C1 non-empty", rd_grant, 1);
    rd_bufable = 1'b1; rd_cachable = 1'b1; #0.1;
    check(rd_grant == 1'b1, "R8", "rd_grant B1C1 non-empty", rd_grant, 1);
    fill_req = 1'b1; #0.1;
    check(fill_grant == 1'b0, "R9", "fill_grant non-empty", fill_grant, 0);
    rd_req = 1'b0; fill_req = 1'b0;
    do_write(32'h2000, 32'hBEEF_0017, 1'b1, 1'b0, 1'b0, 1'b0, 4, "R7");
    drain();
    #1;
    check(buf_empty == 1'b1, "R11", "buf_empty after drain", buf_empty, 1);
    rd_req = 1'b1; rd_bufable = 1'b1; rd_cachable = 1'b0; fill_req = 1'b1; #0.1;
    check(rd_grant == 1'b1, "R8", "rd_grant B1C0 empty", rd_grant, 1);
    check(fill_grant == 1'b1, "R9", "fill_grant empty", fill_grant, 1);
    rd_req = 1'b0; fill_req = 1'b0;

    // R3 direct write behind queued entries must wait and not overtake
    hold_ready = 1'b1;
    for (int i = 0; i < 3; i++)
      do_write(32'h3000 + i * 4, 32'hC000_0000 + i, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R5");
    do_write(32'h3100, 32'hD1D1_D1D1, 1'b0, 1'b0, 1'b1, 1'b0, 3, "R3");
    // R5 swap in B1C0 region goes direct
    do_write(32'h3200, 32'h5A5A_0001, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R5");
    // R6 write-back hit: no memory traffic; miss: queued
    do_write(32'h3300, 32'h0BAD_0001, 1'b1, 1'b1, 1'b1, 1'b0, 0, "R6");
    do_write(32'h3304, 32'h600D_0002, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R6");
    // R4 write-through hit: queued and clean update
    do_write(32'h3308, 32'h600D_0003, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R4");
    drain();

    // Random mix of all attribute combinations
    for (int n = 0; n < 300; n++) begin
      bit b, c, h, s;
      b = $urandom % 2; c = $urandom % 2; h = $urandom % 2; s = (($urandom % 4) == 0);
      do_write($urandom, $urandom, b, c, h, s, 0, "R2");
      if (($urandom % 8) == 0) begin
        #1;
        fill_req = 1'b1; #0.1;
        check(fill_grant == (buf_empty && !(mem_valid && mem_direct)), "R9",
              "fill_grant random", fill_grant, buf_empty);
        fill_req = 1'b0;
      end
    end
    drain();
    check(expq.size() == 0, "R2", "writes left undelivered", expq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule